// File: doc/BRIEF.md
# True-Colour Pixel Path with Palette Overlay

This block takes one pixel word per dot clock and turns it into 8-bit red, green and blue values. The word's direct colour bits go around the colour lookup table and are widened to eight bits per channel. The bits left over in the word form an overlay index into a 256-entry, 24-bit palette held inside the block. An index of zero lets the direct colour through. Any other index replaces it with the palette colour.

The direct colour, the palette result and the blank, horizontal sync and vertical sync strobes all pass through the same number of register stages. They therefore leave the block together, three clock edges after they were sampled. Blanking forces black at the output stage. The palette is loaded through a plain write port with an address and 24 bits of data.

Top module: `tc_overlay_path`

## Requirements
- R1: While `rst` is high at a rising clock edge, all colour outputs and `blank_out`, `hsync_out` and `vsync_out` are 0 after that edge, whatever the other inputs are.
- R2: Inputs sampled at rising edge N show up on the outputs after edge N+2. `blank_out` is `{blank_in}`, `hsync_out` is `hsync_in` and `vsync_out` is `vsync_in` delayed by exactly that amount.
- R3: With `fmt_in` = 0 (5-5-5), blue is pix[4:0], green is pix[9:5] and red is pix[14:10]. Each field is widened to 8 bits as {v[4:0], v[4:2]}. The overlay index is {7'b0, pix[15]}.
- R4: With `fmt_in` = 1 (5-6-5), blue is pix[4:0] and red is pix[15:11], both widened as in R3. Green is pix[10:5], widened as {v[5:0], v[5:4]}. The overlay index is always 0.
- R5: With `fmt_in` = 2 or 3 (8-8-8), blue is pix[7:0], green is pix[15:8] and red is pix[23:16], passed through unchanged. The overlay index is pix[31:24].
- R6: When the overlay index is 0 and blanking is off, the outputs carry the direct colour of R3 to R5.
- R7: When the overlay index is nonzero and blanking is off, the outputs carry that palette entry instead of the direct colour. Entry bits [23:16] go to red, [15:8] to green and [7:0] to blue.
- R8: When the delayed blank (`blank_out`) is 1, all three colour outputs are 0 in that same cycle.
- R9: A write with `pal_we` high at an edge stores `pal_wdata` at `pal_addr`. A pixel sampled one edge before the write edge still reads the old entry. A pixel sampled at the write edge or later reads the new one.
- R10: Bits of `pix_in` that the selected format does not use have no effect on the outputs. For formats 0 and 1 these are bits 31:16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 32 | Pixel word, one per clock |
| fmt_in | input | 2 | Format: 0 = 5-5-5 + 1 overlay bit, 1 = 5-6-5, 2/3 = 8-8-8 + 8 overlay bits |
| blank_in | input | 1 | Blanking strobe |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write address |
| pal_wdata | input | 24 | Palette write data {red, green, blue} |
| red_out | output | 8 | Red result |
| green_out | output | 8 | Green result |
| blue_out | output | 8 | Blue result |
| blank_out | output | 1 | Delayed blank |
| hsync_out | output | 1 | Delayed horizontal sync |
| vsync_out | output | 1 | Delayed vertical sync |

## Verification
Each format is driven with words whose channel fields hold different values and whose top or bottom bits are set. This exposes swapped fields, a wrong widening rule and a leak from unused bits. Overlay tests send 8-8-8 words with indices 0, 1, 0x80 and 0xFF, and 5-5-5 words with the overlay bit on and off, over the same direct colour. This separates "palette wins" from "direct passes". Blank, hsync and vsync are toggled in patterns that differ from one another and are checked every cycle, so any stage skew shows. A palette write is placed one cycle after a pixel that reads the same entry, which tells old-data from new-data read behaviour.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int PIX_W = 32;
  localparam int CH_W  = 8;
  localparam int IDX_W = 8;
  localparam int CTL_W = 3;
  localparam int RGB_W = 3 * CH_W;

  typedef enum logic [1:0] {
    FMT_555  = 2'd0,
    FMT_565  = 2'd1,
    FMT_888  = 2'd2,
    FMT_888B = 2'd3
  } fmt_e;

  typedef struct packed {
    logic [CH_W-1:0] r;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] b;
  } rgb_t;

  function automatic logic [CH_W-1:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic [CH_W-1:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  function automatic rgb_t direct_of(input logic [PIX_W-1:0] p, input fmt_e f);
    rgb_t c;
    case (f)
      FMT_555: begin
        c.b = widen5(p[4:0]);
        c.g = widen5(p[9:5]);
        c.r = widen5(p[14:10]);
      end
      FMT_565: begin
        c.b = widen5(p[4:0]);
        c.g = widen6(p[10:5]);
        c.r = widen5(p[15:11]);
      end
      default: begin
        c.b = p[7:0];
        c.g = p[15:8];
        c.r = p[23:16];
      end
    endcase
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [PIX_W-1:0] p, input fmt_e f);
    case (f)
      FMT_555: return {{(IDX_W-1){1'b0}}, p[15]};
      FMT_565: return '0;
      default: return p[31:24];
    endcase
  endfunction
endpackage

// File: rtl/tc_delay.sv
module tc_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] chain [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= '0;
          else if (i == 0) chain[i] <= d;
          else chain[i] <= chain[(i == 0) ? 0 : i-1];
        end
      end
      assign q = chain[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/tc_unpack.sv
module tc_unpack
  import tc_pkg::*;
#(
  parameter int P_W = PIX_W,
  parameter int I_W = IDX_W,
  parameter int C_W = CTL_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [P_W-1:0] pix,
  input  logic [1:0]     fmt,
  input  logic [C_W-1:0] ctl,
  output rgb_t           q_rgb,
  output logic [I_W-1:0] q_idx,
  output logic [C_W-1:0] q_ctl
);
  fmt_e       fmt_sel;
  rgb_t       dec_rgb;
  logic [I_W-1:0] dec_idx;

  always_comb begin
    fmt_sel = fmt_e'(fmt);
    dec_rgb = direct_of(pix, fmt_sel);
    dec_idx = index_of(pix, fmt_sel);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_rgb <= '0;
      q_idx <= '0;
      q_ctl <= '0;
    end else begin
      q_rgb <= dec_rgb;
      q_idx <= dec_idx;
      q_ctl <= ctl;
    end
  end
endmodule

// File: rtl/tc_palette.sv
module tc_palette #(
  parameter int A_W = 8,
  parameter int D_W = 24
) (
  input  logic           clk,
  input  logic           we,
  input  logic [A_W-1:0] waddr,
  input  logic [D_W-1:0] wdata,
  input  logic [A_W-1:0] raddr,
  output logic [D_W-1:0] rdata
);
  localparam int ENTRIES = 1 << A_W;
  logic [D_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tc_overlay_path.sv
module tc_overlay_path
  import tc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic [1:0]       fmt_in,
  input  logic             blank_in,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             pal_we,
  input  logic [IDX_W-1:0] pal_addr,
  input  logic [RGB_W-1:0] pal_wdata,
  output logic [CH_W-1:0]  red_out,
  output logic [CH_W-1:0]  green_out,
  output logic [CH_W-1:0]  blue_out,
  output logic             blank_out,
  output logic             hsync_out,
  output logic             vsync_out
);
  localparam int MID_W     = RGB_W + 1 + CTL_W;
  localparam int MID_DEPTH = 1;

  rgb_t             s1_rgb;
  logic [RGB_W-1:0] s1_rgb_bits;
  logic [IDX_W-1:0] s1_idx;
  logic [CTL_W-1:0] ctl_in, s1_ctl, s2_ctl, ctl_q;
  logic             ovl_hit;
  logic [RGB_W-1:0] s2_rgb_bits;
  logic             s2_pick;
  logic [RGB_W-1:0] pal_rd;
  logic [RGB_W-1:0] out_q;
  logic             s2_blank;

  assign ctl_in      = {vsync_in, hsync_in, blank_in};
  assign s1_rgb_bits = s1_rgb;
  assign ovl_hit     = (s1_idx != '0);

  tc_unpack u_unpack (
    .clk   (clk),
    .rst   (rst),
    .pix   (pix_in),
    .fmt   (fmt_in),
    .ctl   (ctl_in),
    .q_rgb (s1_rgb),
    .q_idx (s1_idx),
    .q_ctl (s1_ctl)
  );

  tc_palette #(.A_W(IDX_W), .D_W(RGB_W)) u_pal (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_addr),
    .wdata (pal_wdata),
    .raddr (s1_idx),
    .rdata (pal_rd)
  );

  tc_delay #(.W(MID_W), .DEPTH(MID_DEPTH)) u_mid (
    .clk (clk),
    .rst (rst),
    .d   ({s1_rgb_bits, ovl_hit, s1_ctl}),
    .q   ({s2_rgb_bits, s2_pick, s2_ctl})
  );

  assign s2_blank = s2_ctl[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= '0;
      ctl_q <= '0;
    end else begin
      ctl_q <= s2_ctl;
      if (s2_blank)     out_q <= '0;
      else if (s2_pick) out_q <= pal_rd;
      else              out_q <= s2_rgb_bits;
    end
  end

  assign red_out   = out_q[RGB_W-1 -: CH_W];
  assign green_out = out_q[2*CH_W-1 -: CH_W];
  assign blue_out  = out_q[CH_W-1:0];
  assign blank_out = ctl_q[0];
  assign hsync_out = ctl_q[1];
  assign vsync_out = ctl_q[2];
endmodule

// File: rtl/tc_overlay_chk.sv
module tc_overlay_chk (
  input logic        clk,
  input logic        rst,
  input logic        blank_in,
  input logic        hsync_in,
  input logic        vsync_in,
  input logic [7:0]  s1_idx,
  input logic [23:0] s1_rgb_bits,
  input logic [23:0] pal_rd,
  input logic [7:0]  red_out,
  input logic [7:0]  green_out,
  input logic [7:0]  blue_out,
  input logic        blank_out,
  input logic        hsync_out,
  input logic        vsync_out
);
  logic [1:0] age;
  logic       warm;
  logic [23:0] rgb_o;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm  = (age == 2'd3);
  assign rgb_o = {red_out, green_out, blue_out};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (rgb_o == '0 && !blank_out && !hsync_out && !vsync_out)); // R1

  AST_CTRL_ALIGN: assert property (@(posedge clk) disable iff (rst)
    warm |-> (blank_out == $past(blank_in, 3) && hsync_out == $past(hsync_in, 3)
              && vsync_out == $past(vsync_in, 3))); // R2

  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (rst)
    blank_out |-> (rgb_o == '0)); // R8

  AST_DIRECT_PASS: assert property (@(posedge clk) disable iff (rst)
    (warm && !blank_out && $past(s1_idx, 2) == '0) |-> (rgb_o == $past(s1_rgb_bits, 2))); // R6

  AST_PALETTE_WINS: assert property (@(posedge clk) disable iff (rst)
    (warm && !blank_out && $past(s1_idx, 2) != '0) |-> (rgb_o == $past(pal_rd, 1))); // R7
endmodule

bind tc_overlay_path tc_overlay_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .blank_in    (blank_in),
  .hsync_in    (hsync_in),
  .vsync_in    (vsync_in),
  .s1_idx      (s1_idx),
  .s1_rgb_bits (s1_rgb_bits),
  .pal_rd      (pal_rd),
  .red_out     (red_out),
  .green_out   (green_out),
  .blue_out    (blue_out),
  .blank_out   (blank_out),
  .hsync_out   (hsync_out),
  .vsync_out   (vsync_out)
);

// File: tb/sim_tc_overlay_path.sv
module sim_tc_overlay_path;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pix_in = '0;
  logic [1:0]  fmt_in = '0;
  logic        blank_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic        pal_we = 1'b0;
  logic [7:0]  pal_addr = '0;
  logic [23:0] pal_wdata = '0;
  logic [7:0]  red_out, green_out, blue_out;
  logic        blank_out, hsync_out, vsync_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [23:0] pal_m [256];
  logic [23:0] h_rgb [3];
  logic [2:0]  h_ctl [3];
  bit          h_ok  [3];
  string       h_tag [3];

  always #10 clk = ~clk;

  tc_overlay_path u0 (
    .clk(clk), .rst(rst), .pix_in(pix_in), .fmt_in(fmt_in),
    .blank_in(blank_in), .hsync_in(hsync_in), .vsync_in(vsync_in),
    .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
    .red_out(red_out), .green_out(green_out), .blue_out(blue_out),
    .blank_out(blank_out), .hsync_out(hsync_out), .vsync_out(vsync_out)
  );

  function automatic logic [7:0] up5(input logic [4:0] v);
    return 8'((v << 3) | (v >> 2));
  endfunction
  function automatic logic [7:0] up6(input logic [5:0] v);
    return 8'((v << 2) | (v >> 4));
  endfunction

  function automatic logic [23:0] model(input logic [31:0] p, input logic [1:0] f, input logic b);
    logic [7:0]  idx;
    logic [23:0] dir;
    if (f == 2'd0) begin
      idx = {7'd0, p[15]};
      dir = {up5(p[14:10]), up5(p[9:5]), up5(p[4:0])};
    end else if (f == 2'd1) begin
      idx = 8'd0;
      dir = {up5(p[15:11]), up6(p[10:5]), up5(p[4:0])};
    end else begin
      idx = p[31:24];
      dir = p[23:0];
    end
    if (b) return 24'd0;
    return (idx != 8'd0) ? pal_m[idx] : dir;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One dot clock: check the pixel from three steps back, then drive a new one.
  task automatic step(input logic [31:0] p, input logic [1:0] f, input logic b,
                      input logic h, input logic v, input logic we,
                      input logic [7:0] wa, input logic [23:0] wd, input string tag);
    @(negedge clk);
    if (h_ok[2]) begin
      check(h_tag[2], {8'd0, red_out, green_out, blue_out}, {8'd0, h_rgb[2]});
      check("R2", {29'd0, vsync_out, hsync_out, blank_out}, {29'd0, h_ctl[2]});
    end
    for (int i = 2; i > 0; i--) begin
      h_rgb[i] = h_rgb[i-1]; h_ctl[i] = h_ctl[i-1];
      h_ok[i] = h_ok[i-1];   h_tag[i] = h_tag[i-1];
    end
    if (we) pal_m[wa] = wd;
    h_rgb[0] = model(p, f, b);
    h_ctl[0] = {v, h, b};
    h_ok[0]  = 1'b1;
    h_tag[0] = tag;
    pix_in = p; fmt_in = f; blank_in = b; hsync_in = h; vsync_in = v;
    pal_we = we; pal_addr = wa; pal_wdata = wd;
  endtask

  task automatic px(input logic [31:0] p, input logic [1:0] f, input string tag);
    step(p, f, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, tag);
  endtask

  task automatic pal_write(input logic [7:0] a, input logic [23:0] d);
    step(32'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b1, a, d, "R9");
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) step(32'd0, 2'd2, 1'b1, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R8");
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    pix_in = 32'hFFFF_FFFF; fmt_in = 2'd2; blank_in = 1'b0; hsync_in = 1'b1; vsync_in = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R1", {8'd0, red_out, green_out, blue_out}, 32'd0);
      check("R1", {29'd0, vsync_out, hsync_out, blank_out}, 32'd0);
    end
    rst = 1'b0;
    for (int i = 0; i < 3; i++) h_ok[i] = 1'b0;
  endtask

  task automatic t_fmt555();
    px(32'h0000_7C00, 2'd0, "R3");
    px(32'h0000_03E0, 2'd0, "R3");
    px(32'h0000_001F, 2'd0, "R3");
    px(32'h0000_4A52, 2'd0, "R3");
    px(32'hABCD_2108, 2'd0, "R10");
    px(32'hFFFF_0000, 2'd0, "R10");
    flush();
  endtask

  task automatic t_fmt565();
    px(32'h0000_F800, 2'd1, "R4");
    px(32'h0000_07E0, 2'd1, "R4");
    px(32'h0000_0820, 2'd1, "R4");
    px(32'h5A5A_8421, 2'd1, "R10");
    px(32'hFFFF_FFFF, 2'd1, "R4");
    flush();
  endtask

  task automatic t_fmt888();
    px(32'h0012_3456, 2'd2, "R5");
    px(32'h00FE_DCBA, 2'd3, "R5");
    px(32'h0080_0001, 2'd2, "R6");
    flush();
  endtask

  task automatic t_overlay();
    pal_write(8'h01, 24'h11_22_33);
    pal_write(8'h80, 24'hA0_B0_C0);
    pal_write(8'hFF, 24'h0F_1E_2D);
    pal_write(8'h00, 24'hEE_EE_EE);
    px(32'h0155_AA77, 2'd2, "R7");
    px(32'h8055_AA77, 2'd2, "R7");
    px(32'hFF55_AA77, 2'd2, "R7");
    px(32'h0055_AA77, 2'd2, "R6");
    px(32'h0000_CA52, 2'd0, "R7");
    px(32'h0000_4A52, 2'd0, "R6");
    flush();
  endtask

  task automatic t_blank_ctrl();
    step(32'h8012_3456, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0, 8'd0, 24'd0, "R8");
    step(32'h0012_3456, 2'd2, 1'b0, 1'b1, 1'b1, 1'b0, 8'd0, 24'd0, "R6");
    step(32'h0000_FFFF, 2'd0, 1'b1, 1'b0, 1'b1, 1'b0, 8'd0, 24'd0, "R8");
    step(32'h0000_FFFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd0, 24'd0, "R7");
    step(32'h0000_07E0, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 8'd0, 24'd0, "R8");
    step(32'h0000_07E0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 8'd0, 24'd0, "R2");
    flush();
  endtask

  task automatic t_collision();
    pal_write(8'h05, 24'h01_02_03);
    px(32'h0500_0000, 2'd2, "R9");
    step(32'h0500_0000, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 8'h05, 24'h44_55_66, "R9");
    px(32'h0500_0000, 2'd2, "R9");
    flush();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pal_m[i] = 24'd0;
    for (int i = 0; i < 3; i++) begin
      h_ok[i] = 1'b0; h_rgb[i] = '0; h_ctl[i] = '0; h_tag[i] = "";
    end
    t_reset();
    t_fmt555();
    t_fmt565();
    t_fmt888();
    t_overlay();
    t_blank_ctrl();
    t_collision();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule